// File: doc/BRIEF.md
# Opword Classifier and Address-Error Checker

This block sits in the decode stage of a small core whose instructions are 16, 32 or 48 bits long: one 16-bit operation word followed by zero, one or two extension words. For each accepted instruction it splits the operation word into its instruction line, operation-mode field and effective-address mode and register fields. It also works out whether the instruction must take an address error, and why.

Two kinds of fault are detected. The first is a control transfer to an odd target address, meaning bit 0 of the target is set. This check applies to instructions from the PC-relative branch line and the miscellaneous line. The second kind is an indexed addressing form that the core does not support. These are read from the first extension word: a word-sized index register, an index scale of eight, or the full-format extension bit. The result is presented one cycle later through a registered valid/ready stage. A downstream decoder can therefore stall the result without losing it.

Top module: `opw_addr_err_chk`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `out_valid`, `out_cause`, `out_addr_err` and all decoded fields at 0.
- R2: One cycle after a transfer is accepted (`in_valid` and `in_ready` both high at a rising edge), the outputs show the accepted operation word's fields: `out_line` = opword[15:12], `out_opmode` = opword[11:6], `out_ea_mode` = opword[5:3], `out_ea_reg` = opword[2:0].
- R3: `out_cause[0]` (odd target) is 1 exactly when `target_valid` was 1, target bit 0 was 1, and the line was 4'h4 or 4'h6.
- R4: An effective address is indexed when its mode is 3'b110, or when its mode is 3'b111 with register 3'b011. For an indexed EA with `ext1_valid` high, `out_cause[1]` (word index) is 1 exactly when ext1[11] is 0.
- R5: For an indexed EA with `ext1_valid` high, `out_cause[2]` (scale of eight) is 1 exactly when ext1[10:9] is 2'b11.
- R6: For an indexed EA with `ext1_valid` high, `out_cause[3]` (full format) is 1 exactly when ext1[8] is 1.
- R7: When `ext1_valid` is low, or the EA is not indexed, `out_cause[3:1]` is 0 whatever the extension word holds.
- R8: `out_addr_err` is the OR of the four cause bits. Several cause bits may be set for the same instruction.
- R9: `in_ready` is low only while `out_valid` is high and `out_ready` is low. `out_valid` is 1 in the cycle after an accepted transfer. It drops to 0 after a cycle in which `out_ready` is high and no transfer is accepted.
- R10: While `out_valid` is high and `out_ready` is low, all outputs keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The stage can take an instruction |
| opword | input | 16 | Operation word |
| ext1 | input | 16 | First extension word |
| ext1_valid | input | 1 | The first extension word is present |
| target | input | ADDR_W | Change-of-flow target address |
| target_valid | input | 1 | The target address applies to this instruction |
| out_valid | output | 1 | The result is held for the consumer |
| out_ready | input | 1 | The consumer takes the result |
| out_line | output | 4 | Instruction line |
| out_opmode | output | 6 | Operation-mode field |
| out_ea_mode | output | 3 | Effective-address mode field |
| out_ea_reg | output | 3 | Effective-address register field |
| out_cause | output | 4 | Cause bits: [0] odd target, [1] word index, [2] scale of eight, [3] full format |
| out_addr_err | output | 1 | Address error taken |

## Verification
The assertions assume that every input has a known value at each rising edge once reset is released, including `in_valid`, the two valid strobes and `out_ready`. They also assume that the target and extension word are judged only through their valid strobes. They do not assume that `in_valid` is held until it is accepted. The bench keeps inside these limits: it changes inputs only on falling edges and drives every input to a defined value from time zero. It then sweeps all 16 lines, all 64 effective-address codes, all 16 settings of ext1[11:8] and both extension-valid states, with even and odd targets.

// File: rtl/opw_chk_pkg.sv
// Package: shared widths, field encodings and record types for the
// opword classifier. Assumes a 16-bit operation word whose field
// positions are fixed by the instruction format.
package opw_chk_pkg;

    localparam int OPW_W   = 16;
    localparam int LINE_W  = 4;
    localparam int OPM_W   = 6;
    localparam int EAM_W   = 3;
    localparam int EAR_W   = 3;
    localparam int CAUSE_W = 4;
    localparam int NLINES  = 1 << LINE_W;

    // Bit positions inside the operation word (derived from the widths)
    localparam int EAR_LSB  = 0;
    localparam int EAM_LSB  = EAR_LSB + EAR_W;
    localparam int OPM_LSB  = EAM_LSB + EAM_W;
    localparam int LINE_LSB = OPM_LSB + OPM_W;

    // Effective-address encodings that select an indexed form
    localparam logic [EAM_W-1:0] EA_MODE_IDX  = 3'b110;
    localparam logic [EAM_W-1:0] EA_MODE_SPEC = 3'b111;
    localparam logic [EAR_W-1:0] EA_REG_PCIDX = 3'b011;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [OPM_W-1:0]  opmode;
        logic [EAM_W-1:0]  ea_mode;
        logic [EAR_W-1:0]  ea_reg;
    } opw_fields_t;

    // Packed so that bit 0 is the odd-target cause
    typedef struct packed {
        logic full_fmt;
        logic scale8;
        logic word_idx;
        logic odd_tgt;
    } opw_cause_t;

endpackage

// File: rtl/opw_field_split.sv
// Splits an operation word into line, operation mode and effective
// address fields. Purely combinational; assumes the fixed field
// layout given by opw_chk_pkg.
module opw_field_split
    import opw_chk_pkg::*;
(
    input  logic [OPW_W-1:0] opword,
    output opw_fields_t      fields
);

    // Slice each field out at its package-defined position
    always_comb begin
        fields.line    = opword[LINE_LSB +: LINE_W];
        fields.opmode  = opword[OPM_LSB  +: OPM_W];
        fields.ea_mode = opword[EAM_LSB  +: EAM_W];
        fields.ea_reg  = opword[EAR_LSB  +: EAR_W];
    end

endmodule

// File: rtl/opw_tgt_check.sv
// Flags a change-of-flow target with bit 0 set. COF_LINE_MASK has one
// bit per instruction line; a set bit marks a line whose transfers
// are checked. Assumes target is meaningful only with target_valid.
module opw_tgt_check
    import opw_chk_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter logic [NLINES-1:0] COF_LINE_MASK = 16'h0050
) (
    input  logic [LINE_W-1:0] line,
    input  logic [ADDR_W-1:0] target,
    input  logic              target_valid,
    output logic              odd_tgt
);

    logic line_is_cof;

    // Look up whether this line carries a checked control transfer
    always_comb begin
        line_is_cof = COF_LINE_MASK[line];
    end

    // Only bit 0 matters; the upper address bits are consumed here
    generate
        if (ADDR_W > 1) begin : g_hi_bits
            logic unused_tgt_hi;
            assign unused_tgt_hi = ^target[ADDR_W-1:1];
        end
    endgenerate

    // Odd-target cause: valid target, odd, on a checked line
    always_comb begin
        odd_tgt = target_valid && target[0] && line_is_cof;
    end

endmodule

// File: rtl/opw_ext_check.sv
// Checks the first extension word of an indexed effective address for
// forms that must take an address error: word-sized index, scale of
// eight, and full-format extension. Assumes ext1 is meaningful only
// when ext1_valid is high; all causes are 0 otherwise.
module opw_ext_check
    import opw_chk_pkg::*;
#(
    parameter int EXT_W     = 16,
    parameter int SIZE_BIT  = 11,
    parameter int SCALE_LSB = 9,
    parameter int SCALE_W   = 2,
    parameter int FULL_BIT  = 8
) (
    input  logic [EAM_W-1:0] ea_mode,
    input  logic [EAR_W-1:0] ea_reg,
    input  logic [EXT_W-1:0] ext1,
    input  logic             ext1_valid,
    output logic             word_idx,
    output logic             scale8,
    output logic             full_fmt
);

    localparam logic [SCALE_W-1:0] SCALE_MAX = {SCALE_W{1'b1}};

    logic is_indexed;
    logic armed;
    logic unused_ext;

    // Consume the whole extension word; only a few bits are decoded
    assign unused_ext = ^ext1;

    // Decide whether the EA field names an indexed mode
    always_comb begin
        is_indexed = (ea_mode == EA_MODE_IDX) ||
                     ((ea_mode == EA_MODE_SPEC) && (ea_reg == EA_REG_PCIDX));
        armed      = is_indexed && ext1_valid;
    end

    // Derive the three extension-word causes
    always_comb begin
        word_idx = armed && !ext1[SIZE_BIT];
        scale8   = armed && (ext1[SCALE_LSB +: SCALE_W] == SCALE_MAX);
        full_fmt = armed && ext1[FULL_BIT];
    end

endmodule

// File: rtl/opw_out_stage.sv
// One-entry registered valid/ready stage holding the decoded fields,
// the cause bits and the error flag. Accepts whenever the slot is
// empty or being drained; holds its contents while stalled.
module opw_out_stage
    import opw_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  opw_fields_t fields_in,
    input  opw_cause_t  cause_in,
    output logic        out_valid,
    input  logic        out_ready,
    output opw_fields_t fields_q,
    output opw_cause_t  cause_q,
    output logic        err_q
);

    logic accept;

    // Slot is free when empty or when its content leaves this cycle
    always_comb begin
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
    end

    // Capture on accept, drop valid on drain, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            fields_q  <= '0;
            cause_q   <= '0;
            err_q     <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
            fields_q  <= fields_in;
            cause_q   <= cause_in;
            err_q     <= |cause_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/opw_addr_err_chk.sv
// Top: decode-stage opword classifier and address-error checker.
// Splits the opword, evaluates the odd-target and extension-word
// causes combinationally, and registers everything through a single
// valid/ready stage. Assumes inputs are stable across each edge.
module opw_addr_err_chk
    import opw_chk_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter logic [NLINES-1:0] COF_LINE_MASK = 16'h0050
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [OPW_W-1:0]   opword,
    input  logic [OPW_W-1:0]   ext1,
    input  logic               ext1_valid,
    input  logic [ADDR_W-1:0]  target,
    input  logic               target_valid,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [LINE_W-1:0]  out_line,
    output logic [OPM_W-1:0]   out_opmode,
    output logic [EAM_W-1:0]   out_ea_mode,
    output logic [EAR_W-1:0]   out_ea_reg,
    output logic [CAUSE_W-1:0] out_cause,
    output logic               out_addr_err
);

    opw_fields_t fields_d;
    opw_fields_t fields_q;
    opw_cause_t  cause_d;
    opw_cause_t  cause_q;
    logic        odd_tgt;
    logic        word_idx;
    logic        scale8;
    logic        full_fmt;

    opw_field_split u_split (
        .opword (opword),
        .fields (fields_d)
    );

    opw_tgt_check #(
        .ADDR_W        (ADDR_W),
        .COF_LINE_MASK (COF_LINE_MASK)
    ) u_tgt (
        .line         (fields_d.line),
        .target       (target),
        .target_valid (target_valid),
        .odd_tgt      (odd_tgt)
    );

    opw_ext_check #(
        .EXT_W (OPW_W)
    ) u_ext (
        .ea_mode    (fields_d.ea_mode),
        .ea_reg     (fields_d.ea_reg),
        .ext1       (ext1),
        .ext1_valid (ext1_valid),
        .word_idx   (word_idx),
        .scale8     (scale8),
        .full_fmt   (full_fmt)
    );

    // Gather the individual causes into one record
    always_comb begin
        cause_d.odd_tgt  = odd_tgt;
        cause_d.word_idx = word_idx;
        cause_d.scale8   = scale8;
        cause_d.full_fmt = full_fmt;
    end

    opw_out_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .fields_in (fields_d),
        .cause_in  (cause_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .fields_q  (fields_q),
        .cause_q   (cause_q),
        .err_q     (out_addr_err)
    );

    // Unpack the registered record onto the output ports
    always_comb begin
        out_line    = fields_q.line;
        out_opmode  = fields_q.opmode;
        out_ea_mode = fields_q.ea_mode;
        out_ea_reg  = fields_q.ea_reg;
        out_cause   = cause_q;
    end

endmodule

// File: rtl/opw_addr_err_chk_sva.sv
// Checker for opw_addr_err_chk: relates the registered outputs to the
// inputs of the accepted transfer and to the handshake. Bound below.
module opw_addr_err_chk_sva #(
    parameter int          ADDR_W        = 32,
    parameter logic [15:0] COF_LINE_MASK = 16'h0050
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [15:0]       opword,
    input logic [15:0]       ext1,
    input logic              ext1_valid,
    input logic [ADDR_W-1:0] target,
    input logic              target_valid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [3:0]        out_line,
    input logic [5:0]        out_opmode,
    input logic [2:0]        out_ea_mode,
    input logic [2:0]        out_ea_reg,
    input logic [3:0]        out_cause,
    input logic              out_addr_err
);

    logic acc;
    assign acc = in_valid && in_ready;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_cause == 4'h0 && !out_addr_err));

    // R2
    fields_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ({out_line, out_opmode, out_ea_mode, out_ea_reg} == $past(opword)));

    // R3
    odd_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_cause[0] ==
                 $past(target_valid && target[0] && COF_LINE_MASK[opword[15:12]])));

    // R7
    ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ext1_valid) |=> (out_cause[3:1] == 3'b000));

    // R8
    err_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_addr_err == (|out_cause));

    // R9
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R9
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    // R9
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !in_valid) |=> !out_valid);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_cause) && $stable(out_addr_err) &&
             $stable({out_line, out_opmode, out_ea_mode, out_ea_reg})));

endmodule

bind opw_addr_err_chk opw_addr_err_chk_sva #(
    .ADDR_W        (ADDR_W),
    .COF_LINE_MASK (COF_LINE_MASK)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .opword       (opword),
    .ext1         (ext1),
    .ext1_valid   (ext1_valid),
    .target       (target),
    .target_valid (target_valid),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_line     (out_line),
    .out_opmode   (out_opmode),
    .out_ea_mode  (out_ea_mode),
    .out_ea_reg   (out_ea_reg),
    .out_cause    (out_cause),
    .out_addr_err (out_addr_err)
);

// File: tb/opw_addr_err_chk_tb_top.sv
// Bench: exhaustive sweep of line, EA code, ext1[11:8] and valid
// strobes, followed by stall, drain and multi-cause cases.
module opw_addr_err_chk_tb_top;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [15:0]       opword = '0;
    logic [15:0]       ext1 = '0;
    logic              ext1_valid = 1'b0;
    logic [ADDR_W-1:0] target = '0;
    logic              target_valid = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [3:0]        out_line;
    logic [5:0]        out_opmode;
    logic [2:0]        out_ea_mode;
    logic [2:0]        out_ea_reg;
    logic [3:0]        out_cause;
    logic              out_addr_err;

    int n_checks = 0;
    int n_fail   = 0;

    opw_addr_err_chk #(.ADDR_W(ADDR_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .opword       (opword),
        .ext1         (ext1),
        .ext1_valid   (ext1_valid),
        .target       (target),
        .target_valid (target_valid),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_line     (out_line),
        .out_opmode   (out_opmode),
        .out_ea_mode  (out_ea_mode),
        .out_ea_reg   (out_ea_reg),
        .out_cause    (out_cause),
        .out_addr_err (out_addr_err)
    );

    initial forever #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    function automatic logic [15:0] out_word();
        return {out_line, out_opmode, out_ea_mode, out_ea_reg};
    endfunction

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog: actual cycles=%0d expected < %0d", 190000, 190000);
        finish_run();
    end

    initial begin
        logic [15:0] held;
        logic [3:0]  held_cause;

        // R1: reset with garbage offered
        in_valid = 1'b1;
        opword   = 16'hFFFF;
        ext1     = 16'h0600;
        ext1_valid = 1'b1;
        target   = 32'h1;
        target_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 0);
        chk(out_cause == 4'h0, "R1", "out_cause in reset", 32'(out_cause), 0);
        chk(out_addr_err == 1'b0, "R1", "out_addr_err in reset", 32'(out_addr_err), 0);
        chk(out_word() == 16'h0, "R1", "fields in reset", 32'(out_word()), 0);
        chk(in_ready == 1'b1, "R9", "in_ready in reset", 32'(in_ready), 1);
        rst_n = 1'b1;

        // Exhaustive sweep with the consumer always ready
        for (int l = 0; l < 16; l++) begin
            for (int e = 0; e < 64; e++) begin
                for (int n = 0; n < 16; n++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [3:0] ln;
                        logic [5:0] ea;
                        logic [3:0] nb;
                        logic ev, t0, tv, idx, cof;
                        logic [3:0] exp_c;
                        string xr;
                        ln = 4'(l);
                        ea = 6'(e);
                        nb = 4'(n);
                        ev = k[0];
                        t0 = k[1];
                        tv = (nb != 4'd5);
                        opword = {ln, 6'(l * 5 + e + n), ea};
                        ext1 = {4'hA, nb, 8'h5A};
                        ext1_valid = ev;
                        target = 32'h0040_1000 | 32'(t0);
                        target_valid = tv;
                        in_valid = 1'b1;
                        cof = (ln == 4'h4) || (ln == 4'h6);
                        idx = (ea[5:3] == 3'b110) || (ea == 6'b111_011);
                        exp_c[0] = tv && t0 && cof;
                        exp_c[1] = idx && ev && !nb[3];
                        exp_c[2] = idx && ev && (nb[2:1] == 2'b11);
                        exp_c[3] = idx && ev && nb[0];
                        xr = (idx && ev) ? "R4" : "R7";
                        @(negedge clk);
                        chk(out_valid == 1'b1, "R9", "out_valid after accept", 32'(out_valid), 1);
                        chk(out_word() == opword, "R2", "fields", 32'(out_word()), 32'(opword));
                        chk(out_cause[0] == exp_c[0], "R3", "odd target", 32'(out_cause), 32'(exp_c));
                        chk(out_cause[1] == exp_c[1], xr, "word index", 32'(out_cause), 32'(exp_c));
                        chk(out_cause[2] == exp_c[2], (idx && ev) ? "R5" : "R7", "scale8",
                            32'(out_cause), 32'(exp_c));
                        chk(out_cause[3] == exp_c[3], (idx && ev) ? "R6" : "R7", "full format",
                            32'(out_cause), 32'(exp_c));
                        chk(out_addr_err == (|exp_c), "R8", "error flag",
                            32'(out_addr_err), 32'(|exp_c));
                    end
                end
            end
        end

        // R8: explicit multi-cause case on a branch line
        opword = 16'h6_030;           // line 6, EA mode 110 reg 000
        ext1 = 16'h0600;              // word index, scale 8, not full
        ext1_valid = 1'b1;
        target = 32'h0000_2001;
        target_valid = 1'b1;
        @(negedge clk);
        chk(out_cause == 4'b0111, "R8", "multi cause", 32'(out_cause), 32'h7);
        chk(out_addr_err == 1'b1, "R8", "multi cause flag", 32'(out_addr_err), 1);

        // R10: stall holds the result and blocks input
        held = out_word();
        held_cause = out_cause;
        out_ready = 1'b0;
        opword = 16'h4_03B;           // line 4, EA 111/011
        ext1 = 16'h0900;              // long index, scale 1x, full format
        target = 32'h0000_2000;
        #1;
        chk(in_ready == 1'b0, "R9", "in_ready while stalled", 32'(in_ready), 0);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b1, "R10", "valid held", 32'(out_valid), 1);
        chk(out_word() == held, "R10", "fields held", 32'(out_word()), 32'(held));
        chk(out_cause == held_cause, "R10", "cause held", 32'(out_cause), 32'(held_cause));

        // Release: the waiting instruction is taken
        out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R9", "in_ready on release", 32'(in_ready), 1);
        @(negedge clk);
        chk(out_word() == 16'h403B, "R2", "fields after stall", 32'(out_word()), 32'h403B);
        chk(out_cause == 4'b1000, "R6", "full format after stall", 32'(out_cause), 32'h8);

        // R9: drain with nothing offered
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "drain", 32'(out_valid), 0);

        finish_run();
    end

endmodule